// File: doc/BRIEF.md
# Pin-Change Wake and Interrupt Unit

This unit watches a four-pin input port and records every level change, rising or falling, in a sticky per-pin status register. Software can read this register and clear all of it at once, but it cannot write it. Each pin passes through a synchronizer first. A change is the difference between the current synchronized sample and the previous one.

A per-pin enable mask decides which recorded changes raise a request. Software can write the mask but cannot read it back. Each request is also gated by a global flag:
- the hold-release request uses the hold flag;
- the interrupt request uses the interrupt flag.

Both requests are levels. A request stays high until the status register is cleared.

A separate stop-wake mask picks the pins whose falling edges produce a one-cycle stop-exit pulse. This pulse does not depend on the status register or the enable mask. A second four-pin port is only synchronized and presented for reading.

Top module: `pin_change_wake`

## Requirements
- R1: A level change on `watchPins[n]` sets `statusOut[n]` (bit n belongs to pin n). The bit shows after the third rising clock edge that follows the change: two synchronizer stages plus the status register.
- R2: A status bit that is set stays set until a clear is given. Writes to either mask register leave `statusOut` unchanged.
- R3: `clrStatus` held high for one cycle zeroes every status bit whose pin has no change pending in that cycle.
- R4: A clear and a new change on the same pin in the same cycle leave that bit set. The other bits are cleared.
- R5: `holdReq` is high exactly when `holdEnable` is 1 and at least one pin has both its status bit and its enable-mask bit set.
- R6: `intReq` is high exactly when `intEnable` is 1 and at least one pin has both its status bit and its enable-mask bit set.
- R7: A falling edge on a pin whose stop-mask bit is 1 produces exactly one cycle of `stopWake`. This happens in the same cycle that the status bit appears. Rising edges and unselected pins give no pulse, whatever the enable mask holds.
- R8: A write with `wrEn`=1 loads `wrData` into the enable mask when `wrSel`=0 and into the stop mask when `wrSel`=1. Bit n of the data is the bit for pin n.
- R9: During reset (`rstN`=0) and after it, the status register and both masks are 0. Pin levels that are held steady through reset do not record a change.
- R10: `plainLevel` follows `plainPins` two rising edges later. The second port never affects status, requests or `stopWake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| watchPins | input | 4 | Raw pins that are monitored for changes |
| plainPins | input | 4 | Raw pins of the read-only second port |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = enable mask, 1 = stop mask |
| wrData | input | 4 | Write data, one bit per pin |
| clrStatus | input | 1 | Clear the whole status register |
| holdEnable | input | 1 | Global hold-release enable |
| intEnable | input | 1 | Global interrupt enable |
| statusOut | output | 4 | Sticky change status readback |
| plainLevel | output | 4 | Synchronized levels of the second port |
| holdReq | output | 1 | Hold-release request (level) |
| intReq | output | 1 | Interrupt request (level) |
| stopWake | output | 1 | Stop-exit pulse |

## Verification
The masks cannot be read, so a wrong enable mask shows only through `holdReq` and `intReq`. A wrong stop mask shows only through a missing or extra `stopWake` pulse on the next falling edge. The bench therefore checks the requests after every pin move and tries all sixteen values of each mask.

A stale edge-detect history would record a phantom change. That change would appear in `statusOut` within three cycles of reset or of the last pin move.

A clear that wins over a new change would drop a status bit at once. A release of the requests before a clear would break the level behaviour at the next sample.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef struct packed {
    logic loadEnable;
    logic loadStop;
    logic clearStatus;
  } ctrlStrobes_t;
endpackage

// File: rtl/pcw_ctrl.sv
module pcw_ctrl
  import pcw_pkg::*;
(
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic         clrStatus,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.loadEnable  = wrEn && !wrSel;
    strobes.loadStop    = wrEn && wrSel;
    strobes.clearStatus = clrStatus;
  end
endmodule

// File: rtl/pcw_datapath.sv
module pcw_datapath
  import pcw_pkg::*;
#(
  parameter int PINS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [PINS-1:0] watchPins,
  input  logic [PINS-1:0] plainPins,
  input  logic [PINS-1:0] wrData,
  input  logic            holdEnable,
  input  logic            intEnable,
  output logic [PINS-1:0] syncPins,
  output logic [PINS-1:0] prevPins,
  output logic [PINS-1:0] status,
  output logic [PINS-1:0] enMask,
  output logic [PINS-1:0] stopMask,
  output logic [PINS-1:0] plainLevel,
  output logic            holdReq,
  output logic            intReq,
  output logic            stopWake
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PINS-1:0] changeVec;
  logic [PINS-1:0] fallVec;

  // One synchronizer chain per pin. Reset loads the current raw level,
  // so a pin held steady through reset records no change.
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [LAST:0] watchChain;
    logic [LAST:0] plainChain;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        watchChain <= {SYNC_STAGES{watchPins[i]}};
        plainChain <= {SYNC_STAGES{plainPins[i]}};
      end else begin
        watchChain <= {watchChain[LAST-1:0], watchPins[i]};
        plainChain <= {plainChain[LAST-1:0], plainPins[i]};
      end
    end
    assign syncPins[i]   = watchChain[LAST];
    assign plainLevel[i] = plainChain[LAST];
  end

  assign changeVec = syncPins ^ prevPins;
  assign fallVec   = prevPins & ~syncPins;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPins <= syncPins;
      status   <= '0;
      enMask   <= '0;
      stopMask <= '0;
      stopWake <= 1'b0;
    end else begin
      prevPins <= syncPins;
      // A new change takes priority over a clear in the same cycle.
      status   <= (strobes.clearStatus ? '0 : status) | changeVec;
      if (strobes.loadEnable) enMask   <= wrData;
      if (strobes.loadStop)   stopMask <= wrData;
      stopWake <= |(fallVec & stopMask);
    end
  end

  assign holdReq = holdEnable && |(status & enMask);
  assign intReq  = intEnable  && |(status & enMask);
endmodule

// File: rtl/pin_change_wake.sv
module pin_change_wake
  import pcw_pkg::*;
#(
  parameter int PINS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] watchPins,
  input  logic [PINS-1:0] plainPins,
  input  logic            wrEn,
  input  logic            wrSel,
  input  logic [PINS-1:0] wrData,
  input  logic            clrStatus,
  input  logic            holdEnable,
  input  logic            intEnable,
  output logic [PINS-1:0] statusOut,
  output logic [PINS-1:0] plainLevel,
  output logic            holdReq,
  output logic            intReq,
  output logic            stopWake
);
  ctrlStrobes_t    strobes;
  logic [PINS-1:0] syncPins;
  logic [PINS-1:0] prevPins;
  logic [PINS-1:0] enMask;
  logic [PINS-1:0] stopMask;

  pcw_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .clrStatus (clrStatus),
    .strobes   (strobes)
  );

  pcw_datapath #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .watchPins  (watchPins),
    .plainPins  (plainPins),
    .wrData     (wrData),
    .holdEnable (holdEnable),
    .intEnable  (intEnable),
    .syncPins   (syncPins),
    .prevPins   (prevPins),
    .status     (statusOut),
    .enMask     (enMask),
    .stopMask   (stopMask),
    .plainLevel (plainLevel),
    .holdReq    (holdReq),
    .intReq     (intReq),
    .stopWake   (stopWake)
  );
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker
  import pcw_pkg::*;
#(
  parameter int PINS = 4
) (
  input logic            clk,
  input logic            rstN,
  input ctrlStrobes_t    strobes,
  input logic [PINS-1:0] syncPins,
  input logic [PINS-1:0] prevPins,
  input logic [PINS-1:0] status,
  input logic [PINS-1:0] enMask,
  input logic [PINS-1:0] stopMask,
  input logic            holdEnable,
  input logic            intEnable,
  input logic            holdReq,
  input logic            intReq,
  input logic            stopWake
);
  p_change_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (syncPins != prevPins) |=>
      ((status & $past(syncPins ^ prevPins)) == $past(syncPins ^ prevPins)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearStatus |=> ((status & $past(status)) == $past(status)));

  // Covers R3 and R4: after a clear only the same-cycle changes remain.
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearStatus |=> (status == $past(syncPins ^ prevPins)));

  p_hold_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEnable || ((status & enMask) == '0)) |-> !holdReq);

  p_int_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!intEnable || ((status & enMask) == '0)) |-> !intReq);

  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopWake |-> $past((prevPins & ~syncPins & stopMask) != '0));

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEnable |-> !strobes.loadStop);
endmodule

bind pcw_datapath pcw_checker #(.PINS(PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strobes    (strobes),
  .syncPins   (syncPins),
  .prevPins   (prevPins),
  .status     (status),
  .enMask     (enMask),
  .stopMask   (stopMask),
  .holdEnable (holdEnable),
  .intEnable  (intEnable),
  .holdReq    (holdReq),
  .intReq     (intReq),
  .stopWake   (stopWake)
);

// File: tb/sim_pin_change_wake.sv
module sim_pin_change_wake;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] watchPins = 4'b1010;
  logic [3:0] plainPins = 4'b0110;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [3:0] wrData = '0;
  logic       clrStatus = 1'b0;
  logic       holdEnable = 1'b0;
  logic       intEnable = 1'b0;
  logic [3:0] statusOut;
  logic [3:0] plainLevel;
  logic       holdReq;
  logic       intReq;
  logic       stopWake;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [3:0] curPins;
  logic [3:0] expStatus;
  logic [3:0] expEn;
  logic [3:0] expStop;

  pin_change_wake u0 (
    .clk(clk), .rstN(rstN), .watchPins(watchPins), .plainPins(plainPins),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .clrStatus(clrStatus),
    .holdEnable(holdEnable), .intEnable(intEnable), .statusOut(statusOut),
    .plainLevel(plainLevel), .holdReq(holdReq), .intReq(intReq), .stopWake(stopWake)
  );

  initial forever #(PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkReqs(input string tag);
    chk("R5", {tag, " holdReq"}, {3'b0, holdReq}, {3'b0, holdEnable && |(expStatus & expEn)});
    chk("R6", {tag, " intReq"},  {3'b0, intReq},  {3'b0, intEnable && |(expStatus & expEn)});
  endtask

  task automatic writeReg(input logic sel, input logic [3:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick(1);
    wrEn = 1'b0;
    if (sel) expStop = data; else expEn = data;
    chk("R2", "status after mask write", statusOut, expStatus);
  endtask

  task automatic clearAll();
    clrStatus = 1'b1;
    tick(1);
    clrStatus = 1'b0;
    expStatus = '0;
    chk("R3", "status after clear", statusOut, 4'b0000);
  endtask

  task automatic movePins(input logic [3:0] nv);
    logic [3:0] old;
    old = curPins;
    watchPins = nv;
    tick(3);
    expStatus = expStatus | (old ^ nv);
    chk("R1", "status after move", statusOut, expStatus);
    chk("R7", "stopWake pulse", {3'b0, stopWake}, {3'b0, |(old & ~nv & expStop)});
    checkReqs("R5/R6");
    tick(1);
    chk("R7", "stopWake single cycle", {3'b0, stopWake}, 4'b0000);
    curPins = nv;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    curPins = 4'b1010; expStatus = '0; expEn = '0; expStop = '0;
    tick(4);
    // R9: reset state, observed while reset is still applied
    chk("R9", "status in reset", statusOut, 4'b0000);
    rstN = 1'b1;
    tick(4);
    chk("R9", "status after reset", statusOut, 4'b0000);
    chk("R9", "stopWake after reset", {3'b0, stopWake}, 4'b0000);
    chk("R10", "plainLevel after reset", plainLevel, 4'b0110);

    // R9: masks are zero, so with both global flags set no request is raised
    holdEnable = 1'b1; intEnable = 1'b1;
    movePins(4'b0101);
    chk("R9", "holdReq with zero mask", {3'b0, holdReq}, 4'b0000);

    // Sweep over every enable mask and every pin pattern; the stop mask is the complement
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        writeReg(1'b0, 4'(m));
        writeReg(1'b1, ~4'(m));
        holdEnable = p[0];
        intEnable  = p[3] ^ m[0];
        clearAll();
        checkReqs("R5/R6 after clear");
        movePins(4'(p));
      end
    end

    // R2: status is sticky with no clear
    holdEnable = 1'b1; intEnable = 1'b1;
    writeReg(1'b0, 4'b1111);
    clearAll();
    movePins(curPins ^ 4'b0011);
    tick(5);
    chk("R2", "sticky status", statusOut, expStatus);
    checkReqs("R2 sticky reqs");

    // R4: a clear in the same cycle as a new change on pin 2
    watchPins = curPins ^ 4'b0100;
    tick(2);
    clrStatus = 1'b1;
    tick(1);
    clrStatus = 1'b0;
    curPins = watchPins;
    expStatus = 4'b0100;
    chk("R4", "change beats clear", statusOut, 4'b0100);
    tick(3);
    chk("R4", "bit stays after clear", statusOut, 4'b0100);

    // R10: second port is readable and has no side effects
    plainPins = 4'b1001;
    tick(1);
    chk("R10", "plainLevel one edge", plainLevel, 4'b0110);
    tick(1);
    chk("R10", "plainLevel two edges", plainLevel, 4'b1001);
    tick(3);
    chk("R10", "status untouched by plain port", statusOut, 4'b0100);
    chk("R10", "stopWake untouched by plain port", {3'b0, stopWake}, 4'b0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule